// File: doc/BRIEF.md
# Clock Source Mode Controller

This block manages where a small controller's CPU clock comes from and how fast it runs. Software writes a mode register. That register holds a two-bit ratio/source field, an external-oscillator stop bit, a ring-oscillator stop bit and a resonator-type bit (ceramic or RC). The block accepts only the writes that keep the clock system legal. It drives the enable pins of the two oscillators and switches the operation source between the external oscillator and the internal ring oscillator without glitches. From the selected source it produces a CPU clock enable by division.

There are four running states:

- State 1: external source, ring oscillator stopped.
- State 2: external source, both oscillators running.
- State 3: ring source, both oscillators running.
- State 4: ring source, external oscillator stopped.

Two low-power states sit on top of these. A stop command halts both oscillators, and a wait command halts only the CPU clock. An interrupt returns to the running state the block left.

Both oscillators are modelled as levels sampled by a faster control clock `clk`. The CPU clock is delivered as `cpu_tick`, a one-cycle enable in the `clk` domain.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the mode register reads field 10, resonator bit 0 and both stop bits 0. The state code is 3, both oscillator enables are 1 and `src_ring` is 1.
- R2: Field codes are 00 for external/2, 01 for external/8, 11 for external/1 and 10 for the ring oscillator. With the ring source, the CPU tick always runs at source/8.
- R3: Field 11 is accepted only when the written resonator bit (bit 5) is 1. Clearing bit 5 while field 11 stays in force is rejected, and the old value is kept.
- R4: A write of field 10 is rejected, keeping the old field, while the ring-oscillator stop bit (bit 3) is 1.
- R5: Leaving field 10 for an external code is accepted only if `xin_stable` is 1 and the external stop bit (bit 4) is 0.
- R6: Bit 4 can be set only when the resulting field is 10, and writing 0 always clears it. `xin_en` is the inverse of bit 4 outside stop mode.
- R7: Bit 3 can be set only when the resulting field is external, and writing 0 always clears it. `ring_en` is the inverse of bit 3 outside stop mode.
- R8: `status` reads 1 to 4 for the running states named above, 5 in stop mode and 6 in wait mode.
- R9: `cmd_stop` enters stop mode. Stop mode forces both enables to 0 and suppresses `cpu_tick`. `irq` returns to the previous running state, and ticks resume.
- R10: `cmd_wait` enters wait mode. Wait mode suppresses `cpu_tick` but leaves both oscillator enables as in the running state. `irq` returns to that state.
- R11: Register writes during stop or wait mode are ignored.
- R12: `src_ring` changes only on a clock following a cycle in which both enabled oscillator levels were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, faster than both oscillators |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 5 | Written register bits 7..3 |
| cmd_stop | input | 1 | Enter stop mode (pulse) |
| cmd_wait | input | 1 | Enter wait mode (pulse) |
| irq | input | 1 | Wake-up interrupt |
| xin_clk | input | 1 | Sampled external oscillator level |
| xin_stable | input | 1 | External oscillation has settled |
| ring_clk | input | 1 | Sampled ring oscillator level |
| mode_q | output | 5 | Effective register bits 7..3 |
| xin_en | output | 1 | External oscillator enable |
| ring_en | output | 1 | Ring oscillator enable |
| src_ring | output | 1 | Operation source is the ring oscillator |
| cpu_tick | output | 1 | CPU clock enable pulse |
| status | output | 3 | Current state code |

## Verification
The bench builds the block with its default ratios of 2, 8 and 1. It drives the external level with a four-cycle period and the ring level with a six-cycle period. Their low phases therefore overlap every twelve cycles, which gives the source multiplexer frequent safe switching points. These periods also make the tick counts for the three external ratios and the ring ratio (20, 5, 40 and 6 per window) far enough apart to tell apart within a one-tick tolerance.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {PW_RUN = 2'd0, PW_STOP = 2'd1, PW_WAIT = 2'd2} pwr_e;

  localparam logic [1:0] FLD_HIGH = 2'b00;
  localparam logic [1:0] FLD_MID  = 2'b01;
  localparam logic [1:0] FLD_RING = 2'b10;
  localparam logic [1:0] FLD_DBL  = 2'b11;

  // register bits 7..3 as a 5-bit vector: [4:3]=field, [2]=ceramic, [1]=xin stop, [0]=ring stop
  localparam logic [4:0] MODE_RST = 5'b10000;

  localparam logic [2:0] ST_S1   = 3'd1;
  localparam logic [2:0] ST_S2   = 3'd2;
  localparam logic [2:0] ST_S3   = 3'd3;
  localparam logic [2:0] ST_S4   = 3'd4;
  localparam logic [2:0] ST_STOP = 3'd5;
  localparam logic [2:0] ST_WAIT = 3'd6;
endpackage

// File: rtl/clkmode_reg.sv
module clkmode_reg
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  input  logic       xin_stable,
  output logic [4:0] mode_q
);
  logic [1:0] cur_fld, req_fld, new_fld;
  logic       req_cer, new_cer, new_xstop, new_rstop;
  logic       leave_ok, fld_ok;
  logic [4:0] mode_d;

  always_comb begin
    cur_fld  = mode_q[4:3];
    req_fld  = wr_data[4:3];
    req_cer  = wr_data[2];
    leave_ok = (cur_fld != FLD_RING) || (xin_stable && !mode_q[1]);
    case (req_fld)
      FLD_RING: fld_ok = !mode_q[0];
      FLD_DBL:  fld_ok = req_cer && leave_ok;
      default:  fld_ok = leave_ok;
    endcase
    new_fld   = fld_ok ? req_fld : cur_fld;
    new_cer   = (new_fld == FLD_DBL && !req_cer) ? mode_q[2] : req_cer;
    new_xstop = wr_data[1] && (new_fld == FLD_RING);
    new_rstop = wr_data[0] && (new_fld != FLD_RING);
    mode_d    = wr_en ? {new_fld, new_cer, new_xstop, new_rstop} : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/clkmode_src.sv
module clkmode_src #(
  parameter int N_OSC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OSC-1:0] osc_lvl,
  input  logic [N_OSC-1:0] osc_en,
  input  logic             want_ring,
  output logic             src_ring,
  output logic             src_rise
);
  logic [N_OSC-1:0] lvl_m;
  logic both_low, sel_lvl, prev_q, src_d;

  for (genvar g = 0; g < N_OSC; g++) begin : g_mask
    assign lvl_m[g] = osc_lvl[g] & osc_en[g];
  end

  always_comb begin
    both_low = ~|lvl_m;
    src_d    = both_low ? want_ring : src_ring;
    sel_lvl  = src_ring ? lvl_m[1] : lvl_m[0];
    src_rise = sel_lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ring <= 1'b1;
      prev_q   <= 1'b0;
    end else begin
      src_ring <= src_d;
      prev_q   <= sel_lvl;
    end
  end
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div
  import clkmode_pkg::*;
#(
  parameter int DIV_HIGH = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_DBL  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_rise,
  input  logic       use_ring,
  input  logic [1:0] fld,
  input  logic       run,
  output logic       tick
);
  localparam int CW = (DIV_MID > 1) ? $clog2(DIV_MID) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d, last;
  int            div_n;

  always_comb begin
    if (use_ring) div_n = DIV_MID;
    else begin
      case (fld)
        FLD_HIGH: div_n = DIV_HIGH;
        FLD_DBL:  div_n = DIV_DBL;
        default:  div_n = DIV_MID;
      endcase
    end
    last   = (int'(cnt_q) >= div_n - 1);
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (run && src_rise) begin
      if (last) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q & run;
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int DIV_HIGH    = 2,
  parameter int DIV_MID     = 8,
  parameter int DIV_DBL     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  input  logic       cmd_stop,
  input  logic       cmd_wait,
  input  logic       irq,
  input  logic       xin_clk,
  input  logic       xin_stable,
  input  logic       ring_clk,
  output logic [4:0] mode_q,
  output logic       xin_en,
  output logic       ring_en,
  output logic       src_ring,
  output logic       cpu_tick,
  output logic [2:0] status
);
  logic [SYNC_STAGES-1:0] rst_sh;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sh[SYNC_STAGES-1];

  pwr_e pw_q, pw_d;
  logic running, src_rise, ring_fld;

  always_comb begin
    pw_d = pw_q;
    case (pw_q)
      PW_RUN:  if (cmd_stop) pw_d = PW_STOP;
               else if (cmd_wait) pw_d = PW_WAIT;
      default: if (irq) pw_d = PW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pw_q <= PW_RUN;
    else          pw_q <= pw_d;
  end

  assign running = (pw_q == PW_RUN);

  clkmode_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (wr_en && running),
    .wr_data    (wr_data),
    .xin_stable (xin_stable),
    .mode_q     (mode_q)
  );

  assign ring_fld = (mode_q[4:3] == FLD_RING);

  always_comb begin
    xin_en  = !mode_q[1] && (pw_q != PW_STOP);
    ring_en = !mode_q[0] && (pw_q != PW_STOP);
    case (pw_q)
      PW_STOP: status = ST_STOP;
      PW_WAIT: status = ST_WAIT;
      default: begin
        if (ring_fld) status = mode_q[1] ? ST_S4 : ST_S3;
        else          status = mode_q[0] ? ST_S1 : ST_S2;
      end
    endcase
  end

  clkmode_src #(.N_OSC(2)) u_src (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .osc_lvl   ({ring_clk, xin_clk}),
    .osc_en    ({ring_en, xin_en}),
    .want_ring (ring_fld),
    .src_ring  (src_ring),
    .src_rise  (src_rise)
  );

  clkmode_div #(.DIV_HIGH(DIV_HIGH), .DIV_MID(DIV_MID), .DIV_DBL(DIV_DBL)) u_div (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .src_rise (src_rise),
    .use_ring (src_ring),
    .fld      (mode_q[4:3]),
    .run      (running),
    .tick     (cpu_tick)
  );
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xin_clk,
  input logic       ring_clk,
  input logic       xin_stable,
  input logic [4:0] mode_q,
  input logic       xin_en,
  input logic       ring_en,
  input logic       src_ring,
  input logic       cpu_tick,
  input logic [2:0] status
);
  assert_dbl_ceramic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[4:3] == 2'b11) |-> mode_q[2]);

  assert_leave_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == 3'd3 && status == 3'd2) |-> $past(xin_stable));

  assert_xstop_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> (mode_q[4:3] == 2'b10));

  assert_rstop_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |-> (mode_q[4:3] != 2'b10));

  assert_stop_osc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd5) |-> (!xin_en && !ring_en));

  assert_wait_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd6 || status == 3'd5) |-> !cpu_tick);

  assert_lowpower_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd6 || status == 3'd5) |=> $stable(mode_q));

  assert_glitch_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_ring) |-> $past(!(xin_clk && xin_en) && !(ring_clk && ring_en)));
endmodule

bind clkmode_ctrl clkmode_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xin_clk    (xin_clk),
  .ring_clk   (ring_clk),
  .xin_stable (xin_stable),
  .mode_q     (mode_q),
  .xin_en     (xin_en),
  .ring_en    (ring_en),
  .src_ring   (src_ring),
  .cpu_tick   (cpu_tick),
  .status     (status)
);

// File: tb/sim_clkmode_ctrl.sv
`timescale 1ns/1ps
module sim_clkmode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic cmd_stop = 1'b0, cmd_wait = 1'b0, irq = 1'b0;
  logic xin_clk = 1'b0, ring_clk = 1'b0, xin_stable = 1'b1;
  logic [4:0] mode_q;
  logic xin_en, ring_en, src_ring, cpu_tick;
  logic [2:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkmode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_stop(cmd_stop), .cmd_wait(cmd_wait), .irq(irq),
    .xin_clk(xin_clk), .xin_stable(xin_stable), .ring_clk(ring_clk),
    .mode_q(mode_q), .xin_en(xin_en), .ring_en(ring_en),
    .src_ring(src_ring), .cpu_tick(cpu_tick), .status(status)
  );

  // oscillator models: external period 4 clk, ring period 6 clk
  initial begin
    int xc = 0;
    int rc = 0;
    forever begin
      @(negedge clk);
      xc++; rc++;
      if (xc == 2) begin xin_clk = ~xin_clk; xc = 0; end
      if (rc == 3) begin ring_clk = ~ring_clk; rc = 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    chk(act >= exp - 1 && act <= exp + 1, req, act, exp);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d[7:3];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_stop = 1'b1;
    else if (which == 1) cmd_wait = 1'b1;
    else irq = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0; cmd_wait = 1'b0; irq = 1'b0;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cpu_tick) n++;
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 30; i++) @(negedge clk);
  endtask

  // {xin_stable, write byte, expected byte, expected status}
  localparam logic [19:0] VECS [17] = '{
    {1'b1, 8'h00, 8'h00, 3'd2},
    {1'b1, 8'h08, 8'h08, 3'd1},
    {1'b1, 8'h80, 8'h00, 3'd2},
    {1'b1, 8'hC0, 8'h00, 3'd2},
    {1'b1, 8'hE0, 8'hE0, 3'd2},
    {1'b1, 8'hC0, 8'hE0, 3'd2},
    {1'b1, 8'h40, 8'h40, 3'd2},
    {1'b1, 8'h10, 8'h00, 3'd2},
    {1'b1, 8'h80, 8'h80, 3'd3},
    {1'b1, 8'h90, 8'h90, 3'd4},
    {1'b1, 8'h00, 8'h80, 3'd3},
    {1'b1, 8'h88, 8'h80, 3'd3},
    {1'b0, 8'h00, 8'h80, 3'd3},
    {1'b1, 8'h07, 8'h00, 3'd2},
    {1'b1, 8'h0C, 8'h08, 3'd1},
    {1'b1, 8'h88, 8'h08, 3'd1},
    {1'b1, 8'h80, 8'h00, 3'd2}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_eq("R1 mode", int'(mode_q), 8'h80 >> 3);
    chk_eq("R1 status", int'(status), 3);
    chk_eq("R1 xin_en", int'(xin_en), 1);
    chk_eq("R1 ring_en", int'(ring_en), 1);
    chk_eq("R1 src_ring", int'(src_ring), 1);
    // R2 ring source divides by 8: 48 ring edges in 288 cycles
    count_ticks(288, n);
    chk_near("R2 ring /8", n, 6);

    // vector walk: legality rules R3 R4 R5 R6 R7, state codes R8
    for (int v = 0; v < 17; v++) begin
      xin_stable = VECS[v][19];
      do_write(VECS[v][18:11]);
      chk_eq($sformatf("R3-7 vec%0d mode", v), int'(mode_q), int'(VECS[v][10:6]));
      chk_eq($sformatf("R8 vec%0d status", v), int'(status), int'(VECS[v][2:0]));
      xin_stable = 1'b1;
    end

    // R2 external ratios
    settle();
    chk_eq("R2 src external", int'(src_ring), 0);
    count_ticks(160, n);
    chk_near("R2 ext /2", n, 20);
    do_write(8'h40); settle();
    count_ticks(160, n);
    chk_near("R2 ext /8", n, 5);
    do_write(8'hE0); settle();
    count_ticks(160, n);
    chk_near("R3 ext /1 ceramic", n, 40);

    // back to ring, then stop external (R6)
    do_write(8'h80); settle();
    chk_eq("R12 src ring", int'(src_ring), 1);
    do_write(8'h90);
    chk_eq("R6 xin_en off", int'(xin_en), 0);
    chk_eq("R8 state4", int'(status), 4);
    count_ticks(288, n);
    chk_near("R2 ring /8 state4", n, 6);

    // R9 stop mode
    pulse(0);
    chk_eq("R9 status stop", int'(status), 5);
    chk_eq("R9 xin_en", int'(xin_en), 0);
    chk_eq("R9 ring_en", int'(ring_en), 0);
    count_ticks(100, n);
    chk_eq("R9 no ticks", n, 0);
    do_write(8'h80);
    chk_eq("R11 write in stop", int'(mode_q), 8'h90 >> 3);
    pulse(2);
    chk_eq("R9 wake status", int'(status), 4);
    count_ticks(288, n);
    chk_near("R9 ticks resume", n, 6);

    // R10 wait mode
    pulse(1);
    chk_eq("R10 status wait", int'(status), 6);
    chk_eq("R10 ring_en kept", int'(ring_en), 1);
    chk_eq("R10 xin_en kept", int'(xin_en), 0);
    count_ticks(100, n);
    chk_eq("R10 no ticks", n, 0);
    do_write(8'h80);
    chk_eq("R11 write in wait", int'(mode_q), 8'h90 >> 3);
    pulse(2);
    chk_eq("R10 wake status", int'(status), 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule